// File: doc/BRIEF.md
# Banked Debug Comparator Control Window

This block holds the control bytes of three bus-match comparators, named A, B and C, for an on-chip debug unit. All three bytes sit behind one bus address. A 2-bit bank-select input chooses which byte a read returns or a write updates. While the debugger is armed, every write is refused, so the match setup cannot change during a capture.

The three comparators do not implement the same bits. Comparator A implements all eight. Comparator B has no bit 1. Comparator C has no bits 7, 6 and 1. Unimplemented bits always read as zero, and any value written to them is lost.

From each stored byte the block also derives a size qualifier. The qualifier tells the match logic whether the access size captured for the current bus cycle meets that comparator's size condition.

Top module: `dbgcmp_ctl_bank`

## Requirements
- R1: While reset is asserted and right after it, every comparator byte reads 0x00, and all three size qualifiers are 1.
- R2: Each byte has this layout: bit 7 size-check enable, bit 6 size value, bit 5 tag, bit 4 break, bit 3 direction, bit 2 direction enable, bit 1 no-data-bus, bit 0 enable. Bank select 0 reaches A, 1 reaches B and 2 reaches C. A write changes only the selected byte.
- R3: A write attempted while `dbg_armed` is 1 leaves all three bytes unchanged.
- R4: Bit 1 of comparator B always reads 0. Writing a 1 to it has no effect.
- R5: Bits 7, 6 and 1 of comparator C always read 0, whatever value is written.
- R6: Bank select 3 reads 0x00, and a write with bank select 3 changes no byte.
- R7: Reads are combinational from the selected byte. A write takes effect at the clock edge where `bus_wr` and `addr_hit` are both 1 and `dbg_armed` is 0. If `addr_hit` is 0, nothing is written.
- R8: If a comparator's size-check enable is 0 and its tag is 0, its qualifier is 1 for both access sizes.
- R9: If size-check enable is 1 and tag is 0, the qualifier follows the size value. Size value 0 passes only a word access (`acc_is_byte`=0). Size value 1 passes only a byte access (`acc_is_byte`=1).
- R10: If a comparator's tag bit is 1, its qualifier is 1 whatever the size bits and the access size.
- R11: The qualifier of comparator C is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Write strobe for the current bus cycle |
| addr_hit | input | 1 | Bus address matches the shared control address |
| bank_sel | input | 2 | Selects the comparator to reach: 0=A, 1=B, 2=C, 3=none |
| wdata | input | 8 | Write data |
| dbg_armed | input | 1 | Debugger armed; blocks writes while high |
| acc_is_byte | input | 1 | Captured access size: 1=byte, 0=word |
| rdata | output | 8 | Selected control byte, combinational |
| size_ok | output | 3 | Size qualifier per comparator; bit 0=A, 1=B, 2=C |

## Verification
The assertions assume that `bank_sel`, `bus_wr`, `addr_hit`, `dbg_armed` and `wdata` are settled, known values at each rising edge. They also assume these inputs change only away from that edge. The bench meets both assumptions: it drives every input on the falling edge and lets the synchronized reset release before the first write. The random stimulus covers all four bank-select codes, both states of the armed flag and of `addr_hit`, and both access sizes. Directed cases add the masked-bit writes and the tag override.

// File: rtl/dbgcmp_pkg.sv
package dbgcmp_pkg;
  localparam int CMP_N  = 3;
  localparam int CTL_W  = 8;
  localparam int SEL_W  = 2;

  localparam int B_SZEN = 7;
  localparam int B_SZV  = 6;
  localparam int B_TAG  = 5;
  localparam int B_NDB  = 1;

  // Implemented-bit mask of each comparator
  function automatic logic [CTL_W-1:0] impl_mask(input int idx);
    logic [CTL_W-1:0] m;
    m = '1;
    if (idx >= 1) m[B_NDB] = 1'b0;
    if (idx >= 2) begin
      m[B_SZEN] = 1'b0;
      m[B_SZV]  = 1'b0;
    end
    return m;
  endfunction
endpackage

// File: rtl/dbgcmp_rst_sync.sv
module dbgcmp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/dbgcmp_ctl_reg.sv
module dbgcmp_ctl_reg #(
  parameter int          W    = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_stb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (MASK[b]) begin : g_impl
      logic bit_q;
      logic bit_d;
      always_comb begin
        bit_d = bit_q;
        if (wr_stb) bit_d = wdata[b];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_d;
      end
      assign q[b] = bit_q;
    end else begin : g_absent
      assign q[b] = 1'b0;
    end
  end

  // R7: no strobe, no change
  assert_hold_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(q));
  // R2: strobe loads the written data through the mask
  assert_load_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (q == ($past(wdata) & MASK)));
endmodule

// File: rtl/dbgcmp_size_qual.sv
module dbgcmp_size_qual #(
  parameter int W        = 8,
  parameter bit HAS_SIZE = 1'b1
) (
  input  logic [W-1:0] ctl,
  input  logic         acc_is_byte,
  output logic         ok
);
  import dbgcmp_pkg::*;

  if (HAS_SIZE) begin : g_size
    logic tag_ovr;
    logic chk_off;
    logic size_eq;
    always_comb begin
      tag_ovr = ctl[B_TAG];
      chk_off = !ctl[B_SZEN];
      size_eq = (ctl[B_SZV] == acc_is_byte);
      ok      = tag_ovr || chk_off || size_eq;
    end
  end else begin : g_nosize
    assign ok = 1'b1;
  end
endmodule

// File: rtl/dbgcmp_ctl_bank.sv
module dbgcmp_ctl_bank
  import dbgcmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             addr_hit,
  input  logic [SEL_W-1:0] bank_sel,
  input  logic [CTL_W-1:0] wdata,
  input  logic             dbg_armed,
  input  logic             acc_is_byte,
  output logic [CTL_W-1:0] rdata,
  output logic [CMP_N-1:0] size_ok
);
  logic             rst_sync_n;
  logic             wr_ok;
  logic [CMP_N-1:0] wr_stb;
  logic [CTL_W-1:0] ctl_q [CMP_N];

  dbgcmp_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Write gating and bank decode
  always_comb begin
    wr_ok = bus_wr && addr_hit && !dbg_armed;
    for (int k = 0; k < CMP_N; k++) begin
      wr_stb[k] = wr_ok && (bank_sel == SEL_W'(k));
    end
  end

  for (genvar k = 0; k < CMP_N; k++) begin : g_cmp
    dbgcmp_ctl_reg #(
      .W    (CTL_W),
      .MASK (impl_mask(k))
    ) u_reg (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .wr_stb (wr_stb[k]),
      .wdata  (wdata),
      .q      (ctl_q[k])
    );

    dbgcmp_size_qual #(
      .W        (CTL_W),
      .HAS_SIZE (impl_mask(k)[B_SZEN])
    ) u_qual (
      .ctl         (ctl_q[k]),
      .acc_is_byte (acc_is_byte),
      .ok          (size_ok[k])
    );
  end

  // Read mux; unused select code returns zero
  always_comb begin
    rdata = '0;
    for (int k = 0; k < CMP_N; k++) begin
      if (bank_sel == SEL_W'(k)) rdata = ctl_q[k];
    end
  end

  // R3: armed cycle changes nothing
  assert_armed_lock_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dbg_armed |=> ($stable(ctl_q[0]) && $stable(ctl_q[1]) && $stable(ctl_q[2])));
  // R4: B bit 1 never reads set
  assert_b_ndb_zero_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bank_sel == 2'd1) |-> !rdata[B_NDB]);
  // R5: C upper size bits and bit 1 read zero
  assert_c_absent_zero_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bank_sel == 2'd2) |-> (rdata[B_SZEN] == 1'b0 && rdata[B_SZV] == 1'b0 && rdata[B_NDB] == 1'b0));
  // R6: code 3 reads zero
  assert_sel3_zero_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bank_sel == 2'd3) |-> (rdata == '0));
  // R10: tag forces pass
  assert_tag_pass_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctl_q[0][B_TAG] |-> size_ok[0]) and (ctl_q[1][B_TAG] |-> size_ok[1]));
  // R11: comparator C always passes
  assert_c_pass_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    size_ok[2]);
  // R1: reset leaves all qualifiers passing
  assert_reset_pass_R1: assert property (@(posedge clk)
    !rst_sync_n |-> (size_ok == '1));
endmodule

// File: tb/dbgcmp_ctl_bank_tb.sv
module dbgcmp_ctl_bank_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr, addr_hit, dbg_armed, acc_is_byte;
  logic [1:0] bank_sel;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [2:0] size_ok;

  int total = 0;
  int bad   = 0;
  logic [7:0] mdl [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  dbgcmp_ctl_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .addr_hit(addr_hit),
    .bank_sel(bank_sel), .wdata(wdata), .dbg_armed(dbg_armed),
    .acc_is_byte(acc_is_byte), .rdata(rdata), .size_ok(size_ok)
  );

  function automatic logic [7:0] mask_of(input int k);
    case (k)
      0:       return 8'hFF;
      1:       return 8'hFD;
      default: return 8'h3D;
    endcase
  endfunction

  function automatic logic exp_ok(input logic [7:0] c, input logic byt);
    return c[5] || !c[7] || (c[6] == byt);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all();
    bus_wr = 1'b0;
    for (int s = 0; s < 4; s++) begin
      bank_sel = 2'(s);
      #1;
      case (s)
        0: chk("R2", rdata, mdl[0]);
        1: chk("R4", rdata, mdl[1]);
        2: chk("R5", rdata, mdl[2]);
        default: chk("R6", rdata, 8'h00);
      endcase
    end
    for (int b = 0; b < 2; b++) begin
      acc_is_byte = b[0];
      #1;
      chk("R8/R9/R10/R11 size_ok", {5'd0, size_ok},
          {5'd0, 1'b1, exp_ok(mdl[1], b[0]), exp_ok(mdl[0], b[0])});
    end
  endtask

  task automatic do_wr(input logic w, input logic h, input logic [1:0] s,
                       input logic [7:0] d, input logic a);
    @(negedge clk);
    bus_wr = w; addr_hit = h; bank_sel = s; wdata = d; dbg_armed = a;
    @(posedge clk);
    if (w && h && !a && s != 2'd3) mdl[s] = d & mask_of(int'(s));
    #1;
    bus_wr = 1'b0;
    check_all();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; bus_wr = 0; addr_hit = 0; dbg_armed = 0; acc_is_byte = 0;
    bank_sel = 0; wdata = 0;
    for (int k = 0; k < 3; k++) mdl[k] = 8'h00;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    for (int s = 0; s < 3; s++) begin
      bank_sel = 2'(s); #1;
      chk("R1", rdata, 8'h00);
    end
    chk("R1 size_ok", {5'd0, size_ok}, 8'h07);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    check_all();

    // Directed corners
    do_wr(1, 1, 2'd0, 8'hFF, 0);           // R2 full A
    do_wr(1, 1, 2'd1, 8'hFF, 0);           // R4 B drops bit 1
    do_wr(1, 1, 2'd2, 8'hFF, 0);           // R5 C drops 7,6,1
    do_wr(1, 1, 2'd0, 8'h00, 1);           // R3 armed ignored
    chk("R3", mdl[0], 8'hFF);
    do_wr(1, 0, 2'd1, 8'h00, 0);           // R7 no address hit
    do_wr(1, 1, 2'd3, 8'h00, 0);           // R6 write to code 3
    do_wr(0, 1, 2'd2, 8'h00, 0);           // R7 no strobe
    do_wr(1, 1, 2'd0, 8'hC0, 0);           // R9 byte-only on A
    do_wr(1, 1, 2'd1, 8'h80, 0);           // R9 word-only on B
    do_wr(1, 1, 2'd0, 8'hE0, 0);           // R10 tag override
    do_wr(1, 1, 2'd1, 8'h40, 0);           // R8 size check off

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      do_wr(($urandom % 4) != 0, ($urandom % 5) != 0, 2'($urandom),
            8'($urandom), ($urandom % 3) == 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule